// File: doc/BRIEF.md
# Calibration Pulse and Reverse-Power Flag Generator

This block turns a stream of real-power samples into a fast calibration pulse train and a reverse-power indicator. Each sample brings three signed per-phase real-power words and their signed total, qualified by a sample strobe. The magnitude of the total is added into an energy accumulator. Each time the accumulator reaches a threshold, one output pulse is issued and the threshold is subtracted. The threshold is a base full-scale constant divided by a scaling multiple (8, 16 or 160). A three-bit mode selector picks the multiple, so the pulse rate follows power with little averaging.

The pulse has a fixed nominal width. When pulses come closer together than twice that width, the width drops to half the measured interval, so the output keeps a clean high/low shape. Very small loads are rejected so that the meter does not creep at no load. The reverse flag reports whether any phase carried negative power. It changes only at the moment a pulse is issued, so a counter that watches the pulse line reads a flag that is consistent with each pulse.

Top module: `cal_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `cf_out` and `rev_out` are low and the accumulator and mode register are cleared.
- R2: The threshold is `BASE_THRESH / mult`. Here `mult` comes from `mode_sel` = {bit2 = scale select, bit1, bit0}: 0→160, 1→160, 2→16, 3→8, 4→8, 5→16, 6→8, 7→16. With the defaults the thresholds are 25, 250 and 500. With a strobe every cycle and a constant magnitude M that divides the threshold, pulses start every threshold/M cycles.
- R3: Only the magnitude of `pwr_tot` is accumulated, so a negative total produces pulses at the same rate as a positive one.
- R4: On a pulse the accumulator keeps the excess over the threshold. It is not cleared.
- R5: A strobed sample whose total magnitude is below `NOLOAD_MIN` adds nothing and can cause no pulse. A magnitude equal to `NOLOAD_MIN` is accepted.
- R6: The cycle after a threshold crossing, `cf_out` goes high. It stays high for `CF_WIDTH` cycles when the interval since the previous crossing (or since restart) is at least `2*CF_WIDTH`. Otherwise it stays high for half that interval, rounded down, with a minimum of 1 cycle.
- R7: At each threshold crossing, `rev_out` takes the value 1 if any of `pwr_a`, `pwr_b`, `pwr_c` in that sample is negative, and 0 otherwise. Zero counts as non-negative.
- R8: Between threshold crossings `rev_out` holds its value, whatever the phase inputs do.
- R9: A change of `mode_sel` clears the accumulator and the interval count. The sample in the cycle of the change is dropped. With the default thresholds and magnitude 5, the first pulse after a change to a mode with threshold 500 rises 101 cycles after the change is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe qualifying the power words |
| mode_sel | input | 3 | Scaling mode {scale select, sel1, sel0} |
| pwr_a | input | PW | Signed real power, phase A |
| pwr_b | input | PW | Signed real power, phase B |
| pwr_c | input | PW | Signed real power, phase C |
| pwr_tot | input | PW | Signed total real power |
| cf_out | output | 1 | Calibration pulse, active high |
| rev_out | output | 1 | Reverse-power flag |

## Verification
The bench drives a constant power level in each of the eight modes, with exact divisors of the threshold. The measured pulse period therefore distinguishes the three scaling multiples and shows whether the mode decode is wrong. The chosen levels give periods both above and below twice the nominal width, which separates the fixed-width case from the half-period case, down to a period of two cycles. A magnitude that does not divide the threshold shows whether the remainder is kept: an exact count of 40 pulses in 100 cycles, compared with 33 if the remainder were dropped. Further tests check that phase signs flipped mid-period leave the flag untouched until the next pulse, that totals just below and at the no-load limit are rejected and accepted, and that a mode change partway through a period restarts the count.

// File: rtl/cf_pkg.sv
package cf_pkg;

  typedef enum logic [1:0] {
    MUL_8   = 2'd0,
    MUL_16  = 2'd1,
    MUL_160 = 2'd2
  } cf_mul_e;

  // Mode index is {scale select, sel1, sel0}
  function automatic cf_mul_e mode_to_mul(input logic [2:0] m);
    cf_mul_e r;
    unique case (m)
      3'd0, 3'd1:       r = MUL_160;
      3'd2, 3'd5, 3'd7: r = MUL_16;
      default:          r = MUL_8;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cf_thresh_sel.sv
module cf_thresh_sel #(
  parameter int ACC_W       = 24,
  parameter int BASE_THRESH = 4000
) (
  input  logic [2:0]       mode,
  output logic [ACC_W-1:0] thr
);
  localparam int THR_8   = BASE_THRESH / 8;
  localparam int THR_16  = BASE_THRESH / 16;
  localparam int THR_160 = BASE_THRESH / 160;

  always_comb begin
    unique case (cf_pkg::mode_to_mul(mode))
      cf_pkg::MUL_160: thr = ACC_W'(THR_160);
      cf_pkg::MUL_16:  thr = ACC_W'(THR_16);
      default:         thr = ACC_W'(THR_8);
    endcase
  end
endmodule

// File: rtl/cf_energy_acc.sv
module cf_energy_acc #(
  parameter int PW         = 16,
  parameter int ACC_W      = 24,
  parameter int NOLOAD_MIN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic                 restart,
  input  logic signed [PW-1:0] p_tot,
  input  logic [ACC_W-1:0]     thr,
  output logic                 fire
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [PW-1:0]    mag;
  logic             load_ok;
  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] rem;

  always_comb begin
    mag     = p_tot[PW-1] ? $unsigned(-p_tot) : $unsigned(p_tot);
    load_ok = smp_vld && !restart && (mag >= PW'(NOLOAD_MIN));
    sum     = {1'b0, acc_q} + SUM_W'(mag);
    fire    = load_ok && (sum >= {1'b0, thr});
    rem     = ACC_W'(sum - {1'b0, thr});
    if (restart)      acc_nxt = '0;
    else if (fire)    acc_nxt = rem;
    else if (load_ok) acc_nxt = sum[ACC_W-1:0];
    else              acc_nxt = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end
endmodule

// File: rtl/cf_pulse_shaper.sv
module cf_pulse_shaper #(
  parameter int CF_WIDTH = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic restart,
  output logic cf
);
  localparam int GAP_MAX = 2 * CF_WIDTH;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int WC_W    = $clog2(CF_WIDTH + 1);

  logic [GAP_W-1:0] gap_q, gap_nxt;
  logic [WC_W-1:0]  wcnt_q, wcnt_nxt, width;

  always_comb begin
    if (gap_q >= GAP_W'(GAP_MAX)) width = WC_W'(CF_WIDTH);
    else if (gap_q < GAP_W'(2))   width = WC_W'(1);
    else                          width = WC_W'(gap_q >> 1);

    if (fire || restart)               gap_nxt = GAP_W'(1);
    else if (gap_q < GAP_W'(GAP_MAX))  gap_nxt = gap_q + GAP_W'(1);
    else                               gap_nxt = gap_q;

    if (fire)              wcnt_nxt = width;
    else if (wcnt_q != '0) wcnt_nxt = wcnt_q - WC_W'(1);
    else                   wcnt_nxt = wcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_W'(1);
      wcnt_q <= '0;
    end else begin
      gap_q  <= gap_nxt;
      wcnt_q <= wcnt_nxt;
    end
  end

  assign cf = (wcnt_q != '0);
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen #(
  parameter int PW          = 16,
  parameter int ACC_W       = 24,
  parameter int BASE_THRESH = 4000,
  parameter int CF_WIDTH    = 40,
  parameter int NOLOAD_MIN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic [2:0]           mode_sel,
  input  logic signed [PW-1:0] pwr_a,
  input  logic signed [PW-1:0] pwr_b,
  input  logic signed [PW-1:0] pwr_c,
  input  logic signed [PW-1:0] pwr_tot,
  output logic                 cf_out,
  output logic                 rev_out
);
  logic [2:0]       mode_q;
  logic             restart;
  logic [ACC_W-1:0] thr;
  logic             fire;
  logic             neg_now;
  logic             rev_q, rev_nxt;

  assign restart = (mode_sel != mode_q);

  cf_thresh_sel #(.ACC_W(ACC_W), .BASE_THRESH(BASE_THRESH)) u_thr (
    .mode (mode_sel),
    .thr  (thr)
  );

  cf_energy_acc #(.PW(PW), .ACC_W(ACC_W), .NOLOAD_MIN(NOLOAD_MIN)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .restart (restart),
    .p_tot   (pwr_tot),
    .thr     (thr),
    .fire    (fire)
  );

  cf_pulse_shaper #(.CF_WIDTH(CF_WIDTH)) u_shp (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .restart (restart),
    .cf      (cf_out)
  );

  always_comb begin
    neg_now = pwr_a[PW-1] | pwr_b[PW-1] | pwr_c[PW-1];
    rev_nxt = fire ? neg_now : rev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rev_q  <= 1'b0;
    end else begin
      mode_q <= mode_sel;
      rev_q  <= rev_nxt;
    end
  end

  assign rev_out = rev_q;
endmodule

// File: rtl/cal_pulse_gen_chk.sv
module cal_pulse_gen_chk #(
  parameter int PW         = 16,
  parameter int CF_WIDTH   = 40,
  parameter int NOLOAD_MIN = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_vld,
  input logic [2:0]           mode_sel,
  input logic signed [PW-1:0] pwr_a,
  input logic signed [PW-1:0] pwr_b,
  input logic signed [PW-1:0] pwr_c,
  input logic signed [PW-1:0] pwr_tot,
  input logic                 fire,
  input logic                 cf_out,
  input logic                 rev_out
);
  localparam int HR_W = $clog2(CF_WIDTH + 2) + 1;
  logic [HR_W-1:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      high_run <= '0;
    else if (fire)   high_run <= '0;
    else if (cf_out) high_run <= high_run + HR_W'(1);
    else             high_run <= '0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!cf_out && !rev_out));

  assert_noload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (pwr_tot < NOLOAD_MIN) && (pwr_tot > -NOLOAD_MIN)) |-> !fire);

  assert_fire_cf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cf_out);

  assert_width_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    high_run <= HR_W'(CF_WIDTH));

  assert_rev_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rev_out == $past(pwr_a[PW-1] | pwr_b[PW-1] | pwr_c[PW-1])));

  assert_rev_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(rev_out));

  assert_mode_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (mode_sel != $past(mode_sel))) |-> !fire);
endmodule

bind cal_pulse_gen cal_pulse_gen_chk #(
  .PW(PW), .CF_WIDTH(CF_WIDTH), .NOLOAD_MIN(NOLOAD_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mode_sel(mode_sel),
  .pwr_a(pwr_a), .pwr_b(pwr_b), .pwr_c(pwr_c), .pwr_tot(pwr_tot),
  .fire(fire), .cf_out(cf_out), .rev_out(rev_out)
);

// File: tb/cal_pulse_gen_test.sv
module cal_pulse_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic signed [15:0] pwr_a = '0, pwr_b = '0, pwr_c = '0, pwr_tot = '0;
  logic cf_out, rev_out;

  int tests = 0;
  int fails = 0;
  logic prev_cf = 1'b0;
  logic rise = 1'b0;

  always #2 clk = ~clk;

  cal_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mode_sel(mode_sel),
    .pwr_a(pwr_a), .pwr_b(pwr_b), .pwr_c(pwr_c), .pwr_tot(pwr_tot),
    .cf_out(cf_out), .rev_out(rev_out)
  );

  typedef struct packed {
    logic [2:0]         mode;
    logic signed [15:0] ptot;
    logic signed [15:0] pa;
    logic signed [15:0] pb;
    logic signed [15:0] pc;
    logic [15:0]        per;
    logic [7:0]         wid;
    logic               rev;
  } vec_t;

  // thresholds: 160x -> 25, 16x -> 250, 8x -> 500
  localparam vec_t VECS [8] = '{
    '{3'd0,  16'sd5,   16'sd1,  16'sd1, 16'sd1,  16'd5,   8'd2,  1'b0},
    '{3'd4,  16'sd5,   16'sd1,  16'sd0, 16'sd1,  16'd100, 8'd40, 1'b0},
    '{3'd5, -16'sd10, -16'sd3,  16'sd2, 16'sd1,  16'd25,  8'd12, 1'b1},
    '{3'd2,  16'sd2,   16'sd1,  16'sd1, 16'sd1,  16'd125, 8'd40, 1'b0},
    '{3'd3,  16'sd25,  16'sd4,  16'sd4, -16'sd1, 16'd20,  8'd10, 1'b1},
    '{3'd1, -16'sd5,   16'sd5, -16'sd1, 16'sd0,  16'd5,   8'd2,  1'b1},
    '{3'd6,  16'sd50,  16'sd9,  16'sd9, 16'sd9,  16'd10,  8'd5,  1'b0},
    '{3'd7,  16'sd125, 16'sd100, 16'sd2, 16'sd3, 16'd2,   8'd1,  1'b0}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    rise = cf_out && !prev_cf;
    prev_cf = cf_out;
  endtask

  task automatic set_in(input logic [2:0] m, input logic signed [15:0] t,
                        input logic signed [15:0] a, input logic signed [15:0] b,
                        input logic signed [15:0] c);
    mode_sel = m; pwr_tot = t; pwr_a = a; pwr_b = b; pwr_c = c; smp_vld = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    prev_cf = 1'b0;
  endtask

  task automatic wait_rise(output int k, input int limit);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      tick();
      if (rise) begin k = i; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int nr, w1, cnt, k, bad;
    int r [4];
    // R1 reset state
    @(negedge clk);
    chk("R1 cf in reset", cf_out, 0);
    chk("R1 rev in reset", rev_out, 0);

    // Table walk: R2 period, R3 sign of total, R6 width, R7 flag
    for (int v = 0; v < 8; v++) begin
      set_in(VECS[v].mode, VECS[v].ptot, VECS[v].pa, VECS[v].pb, VECS[v].pc);
      do_reset();
      nr = 0; w1 = 0;
      for (int i = 0; i < 4; i++) r[i] = 0;
      for (int i = 0; i < 4 * int'(VECS[v].per) + 60; i++) begin
        tick();
        if (rise) begin
          nr++;
          if (nr <= 4) r[nr-1] = i;
        end
        if (cf_out && nr == 2) w1++;
      end
      chk("R2 pulses seen", nr >= 3, 1);
      chk(VECS[v].ptot < 0 ? "R3 period (negative total)" : "R2 period",
          r[2] - r[1], VECS[v].per);
      chk("R6 width", w1, VECS[v].wid);
      chk("R7 flag", rev_out, VECS[v].rev);
    end

    // R1 asynchronous clear from a busy state with flag set
    set_in(3'd5, -16'sd10, -16'sd3, 16'sd2, 16'sd1);
    do_reset();
    repeat (60) tick();
    chk("R1 flag set before reset", rev_out, 1);
    rst_n = 1'b0;
    tick();
    chk("R1 cf cleared", cf_out, 0);
    chk("R1 rev cleared", rev_out, 0);

    // R5 no-load rejection, both signs, and boundary acceptance
    set_in(3'd0, 16'sd1, -16'sd1, -16'sd1, -16'sd1);
    do_reset();
    cnt = 0;
    for (int i = 0; i < 200; i++) begin tick(); if (rise) cnt++; end
    chk("R5 below limit positive", cnt, 0);
    chk("R5 flag untouched", rev_out, 0);
    pwr_tot = -16'sd1;
    cnt = 0;
    for (int i = 0; i < 200; i++) begin tick(); if (rise) cnt++; end
    chk("R5 below limit negative", cnt, 0);
    pwr_tot = 16'sd2;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin tick(); if (rise) cnt++; end
    chk("R5 at limit accepted", cnt > 0, 1);

    // R4 remainder: magnitude 10 against threshold 25 -> 2 pulses per 5 cycles
    set_in(3'd0, 16'sd10, 16'sd1, 16'sd1, 16'sd1);
    do_reset();
    repeat (20) tick();
    cnt = 0;
    for (int i = 0; i < 100; i++) begin tick(); if (rise) cnt++; end
    chk("R4 remainder kept", cnt, 40);

    // R7/R8 flag changes only with a pulse (threshold 500, period 100)
    set_in(3'd4, 16'sd5, 16'sd1, 16'sd1, 16'sd1);
    do_reset();
    wait_rise(k, 300);
    chk("R7 first pulse", k > 0, 1);
    pwr_a = -16'sd1;
    bad = 0;
    for (int i = 0; i < 60; i++) begin tick(); if (rev_out) bad++; end
    chk("R8 flag held low mid-period", bad, 0);
    wait_rise(k, 200);
    chk("R7 flag set at pulse", rev_out, 1);
    pwr_a = 16'sd0;
    bad = 0;
    for (int i = 0; i < 60; i++) begin tick(); if (!rev_out) bad++; end
    chk("R8 flag held high mid-period", bad, 0);
    wait_rise(k, 200);
    chk("R7 flag clears at pulse", rev_out, 0);

    // R9 mode change mid-period restarts accumulation
    repeat (49) tick();
    mode_sel = 3'd6;
    wait_rise(k, 300);
    chk("R9 restart delay", k, 101);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule